// File: doc/BRIEF.md
# I2C Command-Framed Register Target

This block is an I2C target that gives a controller access to a 256-entry byte register file. It uses a command layer. After the target's 7-bit address with the write bit, the controller sends a command byte. The two low bits of that byte choose the operation:
- `00`: a register transfer. A register pointer follows, then any number of data bytes. Each data byte lands at the pointer, and the pointer then moves up by one.
- `01`: a request to save the whole array to nonvolatile storage.
- `10`: a request to restore the whole array from nonvolatile storage.
- `11`: no action.

A read frame always returns a fixed identification byte first. Register contents then follow from the current pointer.

SCL and SDA are sampled by a fast system clock through two-stage synchronizers. START and STOP are recognised as SDA edges while SCL is high. SDA is pulled low through an output-enable. Save and restore leave the block as single-cycle request pulses. A busy input from the storage engine makes the target refuse its own address. The storage engine moves data through a side port that can read any register and load any register.

Top module: `i2c_cmd_regslave`

## Requirements
- R1: The target ACKs (pulls SDA low in the ninth clock) a byte whose upper 7 bits equal its address (default 7'h6A) and NACKs any other address.
- R2: While `nv_busy` is high, the target NACKs its own address.
- R3: A write frame with command low bits 00, then a pointer byte, then data bytes, stores each data byte at the pointer and increments the pointer after each byte.
- R4: A frame of command 00 and pointer only, followed by a repeated START and a read, makes the read data begin at that pointer.
- R5: A read frame (R/W bit 1) returns the identification byte (default 8'h5A) first, then register data from the pointer, incrementing it per data byte.
- R6: After the controller NACKs a read byte, the target releases SDA. A later read resumes at the register after the last one sent.
- R7: Command low bits 01 produce exactly one single-cycle `save_req` pulse and no `restore_req`.
- R8: Command low bits 10 produce exactly one single-cycle `restore_req` pulse and no `save_req`.
- R9: Command low bits 11 are ACKed, produce no pulse and alter no register. Any byte after a non-00 command in the same frame is NACKed.
- R10: The register pointer wraps from 8'hFF to 8'h00 during a burst.
- R11: After reset every register reads 0, SDA is released and no request is active.
- R12: `nv_rdata` shows the register selected by `nv_addr`. A high `nv_we` loads `nv_wdata` into that register.
- R13: SDA is only changed by the target while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low |
| nv_busy | input | 1 | Storage engine busy; own address is refused |
| save_req | output | 1 | One-cycle request to copy the array to storage |
| restore_req | output | 1 | One-cycle request to reload the array from storage |
| nv_addr | input | 8 | Register index used by the storage engine |
| nv_rdata | output | 8 | Contents of the register at `nv_addr` |
| nv_we | input | 1 | Load `nv_wdata` into the register at `nv_addr` |
| nv_wdata | input | 8 | Data from storage for a restore |

## Verification
The hardest situation to reach from the ports is a repeated START that cuts a write frame right after the pointer byte. The pointer must survive into the following read, and the first read byte must still be the identification byte. The bench builds that exact sequence: command 00 and a pointer mid-burst, then a repeated START and a read. It then reads again in a separate frame to show that the pointer continued past the NACKed byte. A second hard case is the busy refusal. The bench raises `nv_busy` and checks the address NACK. While busy, it loads a register through the storage port, then reads that register back over the bus once busy clears.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_AW = 8;
    localparam int REG_N  = 1 << REG_AW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_PTR,
        ST_WDATA,
        ST_READ,
        ST_HOLD
    } fsm_st_e;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_NOP     = 2'b11
    } op_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic op_e decode_op(input logic [BYTE_W-1:0] b);
        return op_e'(b[1:0]);
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt,
    output logic     scl_lvl
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
        evt.rise  = scl_s & ~scl_d;
        evt.fall  = ~scl_s & scl_d;
        evt.sda   = sda_s;
    end

    assign scl_lvl = scl_s;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array
    import i2c_cmd_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_waddr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [DW-1:0] bus_rdata,
    input  logic          st_we,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_wdata,
    output logic [DW-1:0] st_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            // storage-side load takes precedence on a same-cycle collision
            if (bus_we && !(st_we && st_addr == bus_waddr)) mem[bus_waddr] <= bus_wdata;
            if (st_we) mem[st_addr] <= st_wdata;
        end
    end

    assign bus_rdata = mem[bus_raddr];
    assign st_rdata  = mem[st_addr];
endmodule

// File: rtl/i2c_cmd_fsm.sv
module i2c_cmd_fsm
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR = 7'h6A,
    parameter logic [BYTE_W-1:0] ID_BYTE  = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              nv_busy,
    output logic              sda_oe,
    output logic              save_req,
    output logic              restore_req,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [REG_AW-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_W);

    fsm_st_e           st, nxt;
    logic [BCW-1:0]    bitc;
    logic [BYTE_W-1:0] sh, tx;
    logic [REG_AW-1:0] ptr;
    logic              drv, in_ack, rack, more;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            nxt         <= ST_IDLE;
            bitc        <= '0;
            sh          <= '0;
            tx          <= '0;
            ptr         <= '0;
            drv         <= 1'b0;
            in_ack      <= 1'b0;
            rack        <= 1'b0;
            more        <= 1'b0;
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
        end else begin
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            wr_en       <= 1'b0;
            if (evt.start) begin
                st     <= ST_ADDR;
                bitc   <= '0;
                drv    <= 1'b0;
                in_ack <= 1'b0;
                rack   <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                drv    <= 1'b0;
                in_ack <= 1'b0;
                rack   <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_CMD, ST_PTR, ST_WDATA: begin
                        if (evt.rise && !in_ack && bitc != LAST_BIT) begin
                            sh   <= {sh[BYTE_W-2:0], evt.sda};
                            bitc <= bitc + 1'b1;
                        end else if (evt.fall && in_ack) begin
                            in_ack <= 1'b0;
                            bitc   <= '0;
                            st     <= nxt;
                            if (nxt == ST_READ) begin
                                tx  <= ID_BYTE;
                                drv <= ~ID_BYTE[BYTE_W-1];
                            end else begin
                                drv <= 1'b0;
                            end
                        end else if (evt.fall && bitc == LAST_BIT) begin
                            case (st)
                                ST_ADDR: begin
                                    if (sh[BYTE_W-1:1] == DEV_ADDR && !nv_busy) begin
                                        drv    <= 1'b1;
                                        in_ack <= 1'b1;
                                        nxt    <= sh[0] ? ST_READ : ST_CMD;
                                    end else begin
                                        st <= ST_HOLD;
                                    end
                                end
                                ST_CMD: begin
                                    drv    <= 1'b1;
                                    in_ack <= 1'b1;
                                    nxt    <= ST_HOLD;
                                    case (decode_op(sh))
                                        OP_WRITE:   nxt <= ST_PTR;
                                        OP_SAVE:    save_req <= 1'b1;
                                        OP_RESTORE: restore_req <= 1'b1;
                                        default:    ;
                                    endcase
                                end
                                ST_PTR: begin
                                    ptr    <= sh[REG_AW-1:0];
                                    drv    <= 1'b1;
                                    in_ack <= 1'b1;
                                    nxt    <= ST_WDATA;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= sh;
                                    ptr     <= ptr + 1'b1;
                                    drv     <= 1'b1;
                                    in_ack  <= 1'b1;
                                    nxt     <= ST_WDATA;
                                end
                            endcase
                        end
                    end
                    ST_READ: begin
                        if (!rack) begin
                            if (evt.rise) begin
                                bitc <= bitc + 1'b1;
                            end else if (evt.fall) begin
                                if (bitc == LAST_BIT) begin
                                    drv  <= 1'b0;
                                    rack <= 1'b1;
                                end else begin
                                    tx  <= {tx[BYTE_W-2:0], 1'b0};
                                    drv <= ~tx[BYTE_W-2];
                                end
                            end
                        end else begin
                            if (evt.rise) begin
                                more <= ~evt.sda;
                            end else if (evt.fall) begin
                                rack <= 1'b0;
                                bitc <= '0;
                                if (more) begin
                                    tx  <= rd_data;
                                    drv <= ~rd_data[BYTE_W-1];
                                    ptr <= ptr + 1'b1;
                                end else begin
                                    st <= ST_HOLD;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = drv;
    assign rd_addr = ptr;
endmodule

// File: rtl/i2c_cmd_regslave.sv
module i2c_cmd_regslave
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h6A,
    parameter logic [BYTE_W-1:0] ID_BYTE     = 8'h5A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              nv_busy,
    output logic              save_req,
    output logic              restore_req,
    input  logic [REG_AW-1:0] nv_addr,
    output logic [BYTE_W-1:0] nv_rdata,
    input  logic              nv_we,
    input  logic [BYTE_W-1:0] nv_wdata
);
    bus_evt_t          evt;
    logic              scl_lvl;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .evt(evt), .scl_lvl(scl_lvl)
    );

    i2c_cmd_fsm #(.DEV_ADDR(DEV_ADDR), .ID_BYTE(ID_BYTE)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .nv_busy(nv_busy),
        .sda_oe(sda_oe), .save_req(save_req), .restore_req(restore_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    i2c_reg_array #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(wr_en), .bus_waddr(wr_addr), .bus_wdata(wr_data),
        .bus_raddr(rd_addr), .bus_rdata(rd_data),
        .st_we(nv_we), .st_addr(nv_addr), .st_wdata(nv_wdata), .st_rdata(nv_rdata)
    );
endmodule

// File: rtl/i2c_cmd_regslave_chk.sv
module i2c_cmd_regslave_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic sda_oe,
    input logic save_req,
    input logic restore_req
);
    // R7
    save_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        save_req |=> !save_req);

    // R8
    restore_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        restore_req |=> !restore_req);

    // R7 R8
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(save_req && restore_req));

    // R13
    sda_change_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);
endmodule

bind i2c_cmd_regslave i2c_cmd_regslave_chk u_chk (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
    .save_req(save_req), .restore_req(restore_req)
);

// File: tb/tb_i2c_cmd_regslave.sv
module tb_i2c_cmd_regslave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10 * CLK_PERIOD;
    localparam logic [6:0] DEV = 7'h6A;
    localparam logic [7:0] IDB = 8'h5A;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, save_req, restore_req;
    logic nv_busy = 1'b0, nv_we = 1'b0;
    logic [7:0] nv_addr = '0, nv_wdata = '0, nv_rdata;
    logic sda_line;
    int checks = 0, fails = 0, save_cnt = 0, rest_cnt = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (save_req) save_cnt++;
        if (restore_req) rest_cnt++;
    end

    i2c_cmd_regslave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .nv_busy(nv_busy), .save_req(save_req), .restore_req(restore_req),
        .nv_addr(nv_addr), .nv_rdata(nv_rdata), .nv_we(nv_we), .nv_wdata(nv_wdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic rbyte(input logic last, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(last);
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        nv_addr = a; #CLK_PERIOD; d = nv_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(8'h00, d); chk("R11 reg0", d, 8'h00);
        peek(8'hFF, d); chk("R11 regFF", d, 8'h00);
        chk("R11 sda_oe", {7'd0, sda_oe}, 8'h00);
        chk("R11 reqs", {6'd0, save_req, restore_req}, 8'h00);
    endtask

    task automatic t_addr();
        logic a;
        bus_start(); wbyte({7'h21, 1'b0}, a); bus_stop();
        chk("R1 foreign addr nack", {7'd0, a}, 8'h00);
        chk("R1 released", {7'd0, sda_oe}, 8'h00);
        bus_start(); wbyte({DEV, 1'b0}, a); bus_stop();
        chk("R1 own addr ack", {7'd0, a}, 8'h01);
    endtask

    task automatic t_write();
        logic a;
        logic [7:0] d;
        bus_start(); wbyte({DEV, 1'b0}, a);
        wbyte(8'h00, a); chk("R3 cmd ack", {7'd0, a}, 8'h01);
        wbyte(8'h10, a);
        wbyte(8'hA1, a); wbyte(8'hB2, a); wbyte(8'hC3, a); wbyte(8'hD4, a);
        chk("R3 data ack", {7'd0, a}, 8'h01);
        bus_stop();
        peek(8'h10, d); chk("R3 reg10", d, 8'hA1);
        peek(8'h11, d); chk("R3 reg11", d, 8'hB2);
        peek(8'h13, d); chk("R3 reg13", d, 8'hD4);
        peek(8'h14, d); chk("R3 reg14 untouched", d, 8'h00);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h11, a);
        bus_start(); wbyte({DEV, 1'b1}, a);
        chk("R4 read addr ack", {7'd0, a}, 8'h01);
        rbyte(1'b0, d); chk("R5 id byte", d, IDB);
        rbyte(1'b0, d); chk("R4 first data", d, 8'hB2);
        rbyte(1'b1, d); chk("R5 increment", d, 8'hC3);
        #Q; chk("R6 release after nack", {7'd0, sda_oe}, 8'h00);
        bus_stop();
        bus_start(); wbyte({DEV, 1'b1}, a);
        rbyte(1'b0, d); chk("R5 id again", d, IDB);
        rbyte(1'b1, d); chk("R6 resume", d, 8'hD4);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic a;
        logic [7:0] d;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a); wbyte(8'hFF, a);
        wbyte(8'h11, a); wbyte(8'h22, a); bus_stop();
        peek(8'hFF, d); chk("R10 regFF", d, 8'h11);
        peek(8'h00, d); chk("R10 wrap reg00", d, 8'h22);
    endtask

    task automatic t_cmd(input logic [7:0] code, input int exp_s, input int exp_r, input string req);
        logic a;
        logic [7:0] d;
        int s0, r0;
        s0 = save_cnt; r0 = rest_cnt;
        bus_start(); wbyte({DEV, 1'b0}, a);
        wbyte(code, a); chk({req, " cmd ack"}, {7'd0, a}, 8'h01);
        wbyte(8'h33, a); chk("R9 byte after cmd nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk({req, " save pulses"}, 8'(save_cnt - s0), 8'(exp_s));
        chk({req, " restore pulses"}, 8'(rest_cnt - r0), 8'(exp_r));
        peek(8'h10, d); chk({req, " reg10 kept"}, d, 8'hA1);
    endtask

    task automatic t_busy();
        logic a;
        logic [7:0] d;
        nv_busy = 1'b1;
        bus_start(); wbyte({DEV, 1'b0}, a); bus_stop();
        chk("R2 busy nack", {7'd0, a}, 8'h00);
        @(negedge clk); nv_addr = 8'h40; nv_wdata = 8'h77; nv_we = 1'b1;
        @(negedge clk); nv_we = 1'b0;
        peek(8'h40, d); chk("R12 store load", d, 8'h77);
        nv_busy = 1'b0;
        bus_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h00, a); wbyte(8'h40, a);
        bus_start(); wbyte({DEV, 1'b1}, a);
        chk("R2 ack after busy", {7'd0, a}, 8'h01);
        rbyte(1'b0, d); rbyte(1'b1, d); chk("R12 loaded via bus", d, 8'h77);
        bus_stop();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_addr();
        t_write();
        t_read();
        t_wrap();
        t_cmd(8'h01, 1, 0, "R7");
        t_cmd(8'hFE, 0, 1, "R8");
        t_cmd(8'h03, 0, 0, "R9");
        t_busy();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule